// File: doc/BRIEF.md
# Destination address receive filter with multicast hash

The filter sits at the head of a receive path. It watches the first six bytes of each incoming Ethernet frame, which form the destination address, and decides whether the frame should be kept. Bytes arrive one per cycle with a valid strobe. A start-of-frame strobe marks the first byte, and an end-of-frame strobe marks the last byte of the frame. The filter keeps three running results as the bytes go by: an exact compare against a programmed station address, an all-ones (broadcast) test, and a CRC-32 over the address. The top six bits of the CRC select one bit of a 64-bit multicast hash table.

One cycle after the sixth byte, the filter raises a one-cycle decision strobe. With it come an accept bit and three classification flags at fixed positions of a 16-bit status word. Four control bits choose which classes are accepted, and one of them accepts every complete frame. A frame that ends before its sixth byte still produces a decision strobe, and that decision rejects the frame. Software programs the station address, the hash table and the control bits through a small word-wide write port.

Top module: `mcast_rx_filter`

## Requirements
- R1: After reset the station address and the hash table are all zero, the control bits enable only station-match and broadcast acceptance, and dec_vld_o, accept_o and flags_o are low.
- R2: Register words are selected by reg_addr_i. Word 0 holds station bytes 0..3, with byte 0 in bits [7:0]. Word 1 holds bytes 4..5 in bits [15:0]. Word 2 holds hash bits 0..31 and word 3 holds hash bits 32..63. Word 4 holds the control bits: bit0 accept all, bit1 accept station match, bit2 accept multicast hash hit, bit3 accept broadcast.
- R3: A byte is consumed only in a cycle with byte_vld_i high. A byte with sof_i high is address byte 0 and restarts collection, even in the middle of a frame. Bytes without sof_i that arrive outside a frame, or after the sixth byte, are ignored. Idle cycles between bytes are allowed.
- R4: dec_vld_o is high in exactly the one cycle after the cycle that consumed the sixth address byte, and low in the cycle after that.
- R5: Status bit 14 is set when all six bytes equal the programmed station address. Such a frame is accepted when control bit1 is set.
- R6: Status bit 13 is set when all six bytes are 0xFF. Such a frame is accepted when control bit3 is set, and it never sets bit 15.
- R7: The CRC starts at all ones. Each byte is taken LSB first: feedback is CRC[31] XOR the data bit, the CRC shifts left, and it is XORed with 0x04C11DB7 when the feedback is 1. Status bit 15 is set when byte 0 bit 0 is 1, the address is not broadcast, and the hash bit at index CRC[31:26] is set. Such a frame is accepted when control bit2 is set.
- R8: With control bit0 set, every frame that delivers six address bytes is accepted, whatever its address.
- R9: If eof_i arrives in a frame before the sixth byte, dec_vld_o is high in the next cycle with accept_o and flags_o zero. eof_i outside a frame is ignored. eof_i together with the sixth byte gives a normal decision.
- R10: accept_o and flags_o are zero whenever dec_vld_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Frame byte valid |
| sof_i | input | 1 | Marks the first byte of a frame |
| eof_i | input | 1 | Marks the last byte of a frame |
| byte_i | input | 8 | Frame byte |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word select |
| reg_wdata_i | input | 32 | Register write data |
| dec_vld_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Frame accepted, valid with dec_vld_o |
| flags_o | output | 16 | Status: bit13 broadcast, bit14 station match, bit15 multicast hash hit |

## Verification
The hardest case to reach from the ports is a multicast hash hit, because the table bit that matters depends on a CRC the bench cannot see. The bench therefore computes the CRC-32 index of each multicast address from the stated algorithm. It then programs the table so that only that bit is set, or so that every bit except that one is set. This shows that the filter selects exactly the bit at that index, in the correct half of the table. Restart, short-frame and stray-byte cases are then driven on purpose by cutting frames early or sending bytes without a start strobe.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam int unsigned STA_W      = ADDR_BYTES * 8;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam int unsigned HASH_W     = 64;
  localparam int unsigned HIDX_W     = $clog2(HASH_W);
  localparam int unsigned FLAG_W     = 16;
  localparam int unsigned FLG_BC     = 13;
  localparam int unsigned FLG_PM     = 14;
  localparam int unsigned FLG_MC     = 15;

  typedef enum logic [2:0] {
    REG_STA_LO  = 3'd0,
    REG_STA_HI  = 3'd1,
    REG_HASH_LO = 3'd2,
    REG_HASH_HI = 3'd3,
    REG_CTRL    = 3'd4
  } reg_sel_e;

  // bit3..bit0 = broadcast, multicast, station match, all
  typedef struct packed {
    logic acc_bc;
    logic acc_mc;
    logic acc_pm;
    logic acc_all;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{acc_bc: 1'b1, acc_mc: 1'b0, acc_pm: 1'b1, acc_all: 1'b0};
endpackage

// File: rtl/mrf_regs.sv
module mrf_regs
  import mrf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [STA_W-1:0]  sta_o,
  output logic [HASH_W-1:0] hash_o,
  output ctrl_t             ctrl_o
);
  logic [STA_W-1:0]  sta_q;
  logic [HASH_W-1:0] hash_q;
  ctrl_t             ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sta_q  <= '0;
      hash_q <= '0;
      ctrl_q <= CTRL_RST;
    end else if (we_i) begin
      case (reg_sel_e'(addr_i))
        REG_STA_LO:  sta_q[DATA_W-1:0]          <= wdata_i;
        REG_STA_HI:  sta_q[STA_W-1:DATA_W]      <= wdata_i[STA_W-DATA_W-1:0];
        REG_HASH_LO: hash_q[DATA_W-1:0]         <= wdata_i;
        REG_HASH_HI: hash_q[HASH_W-1:DATA_W]    <= wdata_i;
        REG_CTRL:    ctrl_q                     <= ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
        default: ;
      endcase
    end
  end

  assign sta_o  = sta_q;
  assign hash_o = hash_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/mrf_crc_byte.sv
module mrf_crc_byte
  import mrf_pkg::*;
(
  input  logic [CRC_W-1:0] crc_i,
  input  logic [7:0]       byte_i,
  output logic [CRC_W-1:0] crc_o
);
  // LSB of the byte enters first
  always_comb begin
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc_i;
    for (int b = 0; b < 8; b++) begin
      fb = c[CRC_W-1] ^ byte_i[b];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    crc_o = c;
  end
endmodule

// File: rtl/mrf_addr_track.sv
module mrf_addr_track
  import mrf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_vld_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic [7:0]       byte_i,
  input  logic [STA_W-1:0] sta_i,
  output logic             fin_o,
  output logic             short_o,
  output logic [CRC_W-1:0] crc_o,
  output logic             pm_o,
  output logic             bc_o,
  output logic             mc_o
);
  logic             active_q, fin_q, short_q, pm_q, bc_q, mc_q;
  logic [CNT_W-1:0] cnt_q, idx;
  logic [CRC_W-1:0] crc_q, crc_seed, crc_nx;
  logic             take, last, byte_pm, byte_bc;

  assign take     = byte_vld_i & (sof_i | active_q);
  assign idx      = sof_i ? '0 : cnt_q;
  assign last     = take && (idx == CNT_W'(ADDR_BYTES - 1));
  assign crc_seed = sof_i ? '1 : crc_q;
  assign byte_pm  = (byte_i == sta_i[{idx, 3'b000} +: 8]);
  assign byte_bc  = (byte_i == 8'hFF);

  mrf_crc_byte u_crc (
    .crc_i  (crc_seed),
    .byte_i (byte_i),
    .crc_o  (crc_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      fin_q    <= 1'b0;
      short_q  <= 1'b0;
      cnt_q    <= '0;
      crc_q    <= '1;
      pm_q     <= 1'b0;
      bc_q     <= 1'b0;
      mc_q     <= 1'b0;
    end else begin
      fin_q   <= 1'b0;
      short_q <= 1'b0;
      if (take) begin
        crc_q <= crc_nx;
        pm_q  <= (sof_i | pm_q) & byte_pm;
        bc_q  <= (sof_i | bc_q) & byte_bc;
        if (sof_i) mc_q <= byte_i[0];
        cnt_q <= idx + CNT_W'(1);
        if (last) begin
          fin_q    <= 1'b1;
          active_q <= 1'b0;
        end else if (eof_i) begin
          short_q  <= 1'b1;
          active_q <= 1'b0;
        end else begin
          active_q <= 1'b1;
        end
      end else if (eof_i && active_q) begin
        short_q  <= 1'b1;
        active_q <= 1'b0;
      end
    end
  end

  assign fin_o   = fin_q;
  assign short_o = short_q;
  assign crc_o   = crc_q;
  assign pm_o    = pm_q;
  assign bc_o    = bc_q;
  assign mc_o    = mc_q;
endmodule

// File: rtl/mcast_rx_filter.sv
module mcast_rx_filter
  import mrf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic [7:0]        byte_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              dec_vld_o,
  output logic              accept_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [STA_W-1:0]  sta;
  logic [HASH_W-1:0] hash;
  ctrl_t             ctrl;
  logic              fin, short_f, pm, bc, mc, hash_hit, mc_hit;
  logic [CRC_W-1:0]  crc;
  logic [HIDX_W-1:0] hidx;

  mrf_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .sta_o   (sta),
    .hash_o  (hash),
    .ctrl_o  (ctrl)
  );

  mrf_addr_track u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld_i),
    .sof_i      (sof_i),
    .eof_i      (eof_i),
    .byte_i     (byte_i),
    .sta_i      (sta),
    .fin_o      (fin),
    .short_o    (short_f),
    .crc_o      (crc),
    .pm_o       (pm),
    .bc_o       (bc),
    .mc_o       (mc)
  );

  assign hidx     = crc[CRC_W-1 -: HIDX_W];
  assign hash_hit = hash[hidx];
  assign mc_hit   = mc & ~bc & hash_hit;

  always_comb begin
    flags_o  = '0;
    accept_o = 1'b0;
    if (fin) begin
      flags_o[FLG_BC] = bc;
      flags_o[FLG_PM] = pm;
      flags_o[FLG_MC] = mc_hit;
      accept_o = ctrl.acc_all | (ctrl.acc_pm & pm) | (ctrl.acc_bc & bc) | (ctrl.acc_mc & mc_hit);
    end
  end

  assign dec_vld_o = fin | short_f;
endmodule

// File: rtl/mcast_rx_filter_chk.sv
module mcast_rx_filter_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        dec_vld_o,
  input logic        accept_o,
  input logic [15:0] flags_o,
  input logic        fin_i,
  input logic        short_i,
  input logic [3:0]  ctrl_i
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_vld_o |-> (!accept_o && flags_o == '0)); // R10
  AST_SHORT_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_i |-> (dec_vld_o && !accept_o && flags_o == '0)); // R9
  AST_BC_NOT_MC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[13] |-> !flags_o[15]); // R6
  AST_PROMISC_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && ctrl_i[0]) |-> accept_o); // R8
  AST_FIN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> !fin_i); // R4
  AST_ACCEPT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (ctrl_i[0] || (ctrl_i[1] && flags_o[14]) || (ctrl_i[3] && flags_o[13])
                  || (ctrl_i[2] && flags_o[15]))); // R5 R7
endmodule

bind mcast_rx_filter mcast_rx_filter_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dec_vld_o (dec_vld_o),
  .accept_o  (accept_o),
  .flags_o   (flags_o),
  .fin_i     (fin),
  .short_i   (short_f),
  .ctrl_i    (ctrl)
);

// File: tb/mcast_rx_filter_tb_top.sv
module mcast_rx_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, eof = 1'b0, vld = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        we = 1'b0;
  logic [2:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic        dec_vld, acc;
  logic [15:0] flags;

  int n_chk = 0;
  int n_fail = 0;
  logic       r_vld, r_acc, r_post;
  logic [2:0] r_flg;

  always #2 clk = ~clk;

  mcast_rx_filter dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .byte_vld_i  (vld),
    .sof_i       (sof),
    .eof_i       (eof),
    .byte_i      (byte_d),
    .reg_we_i    (we),
    .reg_addr_i  (waddr),
    .reg_wdata_i (wdata),
    .dec_vld_o   (dec_vld),
    .accept_o    (acc),
    .flags_o     (flags)
  );

  typedef struct packed {
    logic [47:0] addr;   // byte 0 in [47:40]
    logic [3:0]  ctrl;
    logic [1:0]  hmode;  // 0 empty, 1 only own bit, 2 all but own bit
    logic        acc;
    logic [2:0]  flg;    // {bit15, bit14, bit13}
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{48'h021122334455, 4'b1010, 2'd0, 1'b1, 3'b010},
    '{48'h021122334455, 4'b1000, 2'd0, 1'b0, 3'b010},
    '{48'hFFFFFFFFFFFF, 4'b1010, 2'd0, 1'b1, 3'b001},
    '{48'hFFFFFFFFFFFF, 4'b0010, 2'd0, 1'b0, 3'b001},
    '{48'hFFFFFFFFFFFF, 4'b0100, 2'd1, 1'b0, 3'b001},
    '{48'h01005E000001, 4'b0100, 2'd1, 1'b1, 3'b100},
    '{48'h01005E000001, 4'b0100, 2'd2, 1'b0, 3'b000},
    '{48'h01005E000001, 4'b1010, 2'd1, 1'b0, 3'b100},
    '{48'h021122334456, 4'b1010, 2'd0, 1'b0, 3'b000},
    '{48'h021122334456, 4'b0001, 2'd0, 1'b1, 3'b000},
    '{48'h333300000001, 4'b0110, 2'd1, 1'b1, 3'b100},
    '{48'h0A1122334455, 4'b1010, 2'd0, 1'b0, 3'b000},
    '{48'h0A1122334455, 4'b0100, 2'd1, 1'b0, 3'b000}
  };

  function automatic logic [5:0] hash_idx(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  d;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      d = a[47-8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        fb = c[31] ^ d[j];
        c  = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c[31:26];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_hash(input logic [1:0] mode, input logic [47:0] a);
    logic [63:0] h;
    h = '0;
    if (mode == 2'd1) h[hash_idx(a)] = 1'b1;
    if (mode == 2'd2) begin h = '1; h[hash_idx(a)] = 1'b0; end
    wr(3'd2, h[31:0]);
    wr(3'd3, h[63:32]);
  endtask

  task automatic send(input logic [47:0] a, input int nb, input bit eof_last, input bit gaps);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      sof = (i == 0); vld = 1'b1; byte_d = a[47-8*i -: 8];
      eof = eof_last && (i == nb - 1);
      if (gaps && i < nb - 1) begin
        @(negedge clk);
        sof = 1'b0; vld = 1'b0; eof = 1'b0;
      end
    end
    @(negedge clk);
    sof = 1'b0; vld = 1'b0; eof = 1'b0;
    r_vld = dec_vld; r_acc = acc; r_flg = {flags[15], flags[14], flags[13]};
    @(negedge clk);
    r_post = dec_vld;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle out of reset
    chk("R1 dec_vld in reset", 32'(dec_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 accept idle", 32'(acc), 0);
    chk("R10 flags idle", 32'(flags), 0);

    // R1: defaults accept broadcast and station (zero) address, hash empty
    send(48'hFFFFFFFFFFFF, 6, 1'b1, 1'b0);
    chk("R1 bcast accepted by default", 32'(r_acc), 1);
    send(48'h000000000000, 6, 1'b1, 1'b0);
    chk("R1 zero station match", 32'({r_acc, r_flg}), 32'b1010);
    wr(3'd4, 32'h4);
    send(48'h01005E000001, 6, 1'b1, 1'b0);
    chk("R1 hash table cleared", 32'({r_acc, r_flg}), 32'b0000);

    // R2: station address word layout
    wr(3'd0, 32'h33221102);
    wr(3'd1, 32'h00005544);

    for (int k = 0; k < NV; k++) begin
      wr(3'd4, {28'd0, VEC[k].ctrl});
      set_hash(VEC[k].hmode, VEC[k].addr);
      send(VEC[k].addr, 6, 1'b1, 1'b0);
      chk($sformatf("R4 vec%0d dec_vld", k), 32'(r_vld), 1);
      chk($sformatf("R4 vec%0d dec_vld drops", k), 32'(r_post), 0);
      chk($sformatf("R5 R6 R7 R8 vec%0d accept", k), 32'(r_acc), 32'(VEC[k].acc));
      chk($sformatf("R5 R6 R7 vec%0d flags", k), 32'(r_flg), 32'(VEC[k].flg));
    end

    // R9: short frame rejected even when accepting all
    wr(3'd4, 32'h1);
    send(48'hFFFFFFFFFFFF, 3, 1'b1, 1'b0);
    chk("R9 short dec_vld", 32'(r_vld), 1);
    chk("R9 short reject", 32'({r_acc, r_flg}), 0);
    send(48'hFFFFFFFFFFFF, 1, 1'b1, 1'b0);
    chk("R9 one-byte frame reject", 32'({r_vld, r_acc}), 32'b10);

    // R9: eof outside a frame ignored
    @(negedge clk); eof = 1'b1;
    @(negedge clk); eof = 1'b0;
    chk("R9 stray eof", 32'(dec_vld), 0);

    // R9: eof with sixth byte is a normal decision
    wr(3'd4, 32'hA);
    send(48'h021122334455, 6, 1'b1, 1'b0);
    chk("R9 eof on sixth byte", 32'({r_vld, r_acc, r_flg}), 32'b11010);

    // R3: idle gaps between bytes, eof not asserted
    send(48'h021122334455, 6, 1'b0, 1'b1);
    chk("R3 gapped frame", 32'({r_vld, r_acc, r_flg}), 32'b11010);

    // R3: sof restarts mid-frame
    send(48'h021122000000, 3, 1'b0, 1'b0);
    chk("R3 partial no decision", 32'(r_vld), 0);
    send(48'hFFFFFFFFFFFF, 6, 1'b0, 1'b0);
    chk("R3 restart decision", 32'({r_vld, r_acc, r_flg}), 32'b11001);

    // R3: bytes without sof outside a frame ignored
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); vld = 1'b1; sof = 1'b0; byte_d = 8'hFF;
      chk("R3 stray bytes no decision", 32'(dec_vld), 0);
    end
    @(negedge clk); vld = 1'b0;
    chk("R3 stray bytes no decision end", 32'(dec_vld), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule